// File: doc/BRIEF.md
# Multi-channel general-purpose timer

A memory-mapped timer peripheral with five independent 32-bit up-counters. Each channel takes one of two count-enable strobes, a fast system strobe or a slow real-time strobe, and divides it through a 4-bit prescaler code. It then counts up and compares the count against a programmable compare value. Each channel runs in one of four modes. A single-shot channel stops itself on a match. A periodic channel restarts from zero on a match. A wrapping channel flags the match and keeps counting. A plain timebase channel counts and never flags. The count can be read back at any time, so a channel in timebase mode serves as a free-running time reference.

All status and enable bits sit in three shared registers, and one interrupt line combines every enabled pending source. Both strobes arrive as single-cycle enables in the one clock domain of the block. The register bus is a plain single-cycle port. A write is taken on the edge where `bus_wen` is high. Read data is a combinational function of `bus_addr`. The port has no back-pressure, so every access completes in the cycle it is presented.

To arm a channel, software writes the compare value first. It then acknowledges the channel's status bit. Finally it writes the control register once, with the mode, the enable bit and the clear bit all set.

Top module: `multi_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low. Every channel is stopped, in single-shot mode, on the system strobe, with divide-by-1.
- R2: Channel n (1..5) has four registers: control at byte offset 0x10·n, clock select at +0x4, count at +0x8 and compare at +0xC. The shared registers are interrupt enable at 0x00, status at 0x04 and acknowledge at 0x08. Channel n owns bit n−1 in each shared register.
- R3: In the control register, bit 0 is the run enable and bits 5:4 are the mode (0 single-shot, 1 periodic, 2 wrapping, 3 timebase). Bit 1 is a clear strobe. Writing it as 1 zeroes the count and the prescaler on that edge, and it always reads back as 0.
- R4: Bit 4 of the clock-select register picks the strobe. A 0 selects `sys_tick` and a 1 selects `rtc_tick`.
- R5: Bits 3:0 of the clock-select register give the prescaler code. Codes 0..12 divide by code+1, and codes 13, 14 and 15 divide by 16, 32 and 64. The prescaler rolls over, and the count advances, on the selected strobe that finds it at or above divisor−1.
- R6: In single-shot mode, when an advance would make the count equal the compare value, the count takes that value, the status bit sets and the run enable drops.
- R7: In periodic mode, a match sets the status bit and the count returns to 0.
- R8: In wrapping mode, a match sets the status bit and the count keeps advancing past the compare value, through 32-bit wrap.
- R9: In timebase mode, a match never sets the status bit.
- R10: The status bit latches whether or not its enable bit is set. `irq` is high exactly when some status bit and its matching enable bit are both 1.
- R11: Writing 1 to an acknowledge bit clears that status bit. A match on the same edge wins over the acknowledge. The acknowledge register reads 0.
- R12: While the run enable is 0, the count holds its value. On any edge with a control write, the channel's prescaler and count take no step.
- R13: Reads of unmapped offsets (0x0C, offsets that are not word aligned, and 0x60 and above) return 0, and writes to them change nothing. The count register is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_tick | input | 1 | Fast count strobe, one cycle wide |
| rtc_tick | input | 1 | Slow count strobe, one cycle wide |
| bus_wen | input | 1 | Write strobe, taken on the rising edge |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Combined interrupt |

## Verification
A register write takes effect on the edge that samples it, and its read-back is valid in the same cycle from then on. A step of the count shows at the read port just after the edge on which the prescaler rolls over. A match shows in the status bit, and through the enable mask on `irq`, on that same edge, with no added pipeline stage. The bench advances a behavioural model on every rising edge with the inputs held since the previous falling edge. One nanosecond after the edge it compares `irq` and the read data for the current address against that model. Directed reads and timed waits then pin down the exact counts for the divider codes and the four modes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE   = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_WRAP     = 2'd2,
    MODE_TIMEBASE = 2'd3
  } tmr_mode_e;

  localparam int CTL_RUN_BIT  = 0;
  localparam int CTL_CLR_BIT  = 1;
  localparam int CTL_MODE_LSB = 4;
  localparam int SEL_SRC_BIT  = 4;
  localparam int CODE_W       = 4;
  localparam int PSC_W        = 7;

  // Divisor for a prescaler code: linear up to 13, then 16, 32, 64.
  function automatic logic [PSC_W-1:0] code_to_div(input logic [CODE_W-1:0] code);
    logic [PSC_W-1:0] d;
    case (code)
      4'd13:   d = 7'd16;
      4'd14:   d = 7'd32;
      4'd15:   d = 7'd64;
      default: d = {3'b000, code} + 7'd1;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              clr,
  input  logic [CODE_W-1:0] code,
  output logic              step
);

  logic [PSC_W-1:0] pcnt;
  logic [PSC_W-1:0] lim;

  assign lim  = code_to_div(code) - 7'd1;
  assign step = tick && (pcnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (clr) begin
      pcnt <= '0;
    end else if (tick) begin
      if (pcnt >= lim) pcnt <= '0;
      else             pcnt <= pcnt + 7'd1;
    end
  end

  assert_psc_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && (pcnt < lim)) |=> (pcnt == $past(pcnt) + 7'd1));

  assert_psc_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pcnt == '0));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_tick,
  input  logic              rtc_tick,
  input  logic              ctl_we,
  input  logic              sel_we,
  input  logic              cmp_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctl_q,
  output logic [DATA_W-1:0] sel_q,
  output logic [DATA_W-1:0] cnt_q,
  output logic [DATA_W-1:0] cmp_q,
  output logic              hit
);

  logic              run;
  tmr_mode_e         mode;
  logic              src;
  logic [CODE_W-1:0] code;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cmp;
  logic [CNT_W-1:0]  nxt;
  logic              clr;
  logic              strobe;
  logic              step;
  logic              match;

  assign clr    = ctl_we && wdata[CTL_CLR_BIT];
  assign strobe = (src ? rtc_tick : sys_tick) && run && !ctl_we;

  tmr_prescaler u_psc (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (strobe),
    .clr  (clr),
    .code (code),
    .step (step)
  );

  assign nxt   = cnt + 1'b1;
  assign match = step && (nxt == cmp);
  assign hit   = match && (mode != MODE_TIMEBASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      mode <= MODE_SINGLE;
      cnt  <= '0;
    end else if (ctl_we) begin
      run  <= wdata[CTL_RUN_BIT];
      mode <= tmr_mode_e'(wdata[CTL_MODE_LSB +: 2]);
      if (clr) cnt <= '0;
    end else if (step) begin
      if (match && mode == MODE_PERIODIC) cnt <= '0;
      else                                cnt <= nxt;
      if (match && mode == MODE_SINGLE)   run <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src  <= 1'b0;
      code <= '0;
      cmp  <= '0;
    end else begin
      if (sel_we) begin
        src  <= wdata[SEL_SRC_BIT];
        code <= wdata[CODE_W-1:0];
      end
      if (cmp_we) cmp <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    ctl_q = '0;
    ctl_q[CTL_RUN_BIT]         = run;
    ctl_q[CTL_MODE_LSB +: 2]   = mode;
    sel_q = '0;
    sel_q[SEL_SRC_BIT]         = src;
    sel_q[CODE_W-1:0]          = code;
    cnt_q = '0;
    cnt_q[CNT_W-1:0]           = cnt;
    cmp_q = '0;
    cmp_q[CNT_W-1:0]           = cmp;
  end

  assert_clear_zeroes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  assert_single_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode == MODE_SINGLE) |=> !run);

  assert_periodic_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode == MODE_PERIODIC) |=> (cnt == '0));

  assert_idle_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ctl_we) |=> $stable(cnt));

endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
  parameter int N_CH = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_we,
  input  logic            ack_we,
  input  logic [N_CH-1:0] wbits,
  input  logic [N_CH-1:0] hits,
  output logic [N_CH-1:0] en_q,
  output logic [N_CH-1:0] stat_q,
  output logic            irq
);

  logic [N_CH-1:0] ack_mask;

  assign ack_mask = ack_we ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      stat_q <= '0;
    end else begin
      if (en_we) en_q <= wbits;
      stat_q <= (stat_q & ~ack_mask) | hits;
    end
  end

  assign irq = |(stat_q & en_q);

  for (genvar k = 0; k < N_CH; k++) begin : g_chk
    assert_ack_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_we && wbits[k] && !hits[k]) |=> !stat_q[k]);

    assert_stat_needs_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[k]) |-> $past(hits[k]));
  end

endmodule

// File: rtl/multi_timer.sv
module multi_timer
  import tmr_pkg::*;
#(
  parameter int N_CH   = 5,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_tick,
  input  logic              rtc_tick,
  input  logic              bus_wen,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  localparam int BLK_W = ADDR_W - 4;

  logic [BLK_W-1:0] blk;
  logic [1:0]       slot;
  logic             aligned;
  logic             shared_hit;

  assign blk        = bus_addr[ADDR_W-1:4];
  assign slot       = bus_addr[3:2];
  assign aligned    = (bus_addr[1:0] == 2'b00);
  assign shared_hit = aligned && (blk == '0);

  logic [DATA_W-1:0] ctl_q [N_CH];
  logic [DATA_W-1:0] sel_q [N_CH];
  logic [DATA_W-1:0] cnt_q [N_CH];
  logic [DATA_W-1:0] cmp_q [N_CH];
  logic [N_CH-1:0]   hits;
  logic [N_CH-1:0]   en_q;
  logic [N_CH-1:0]   stat_q;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    localparam logic [BLK_W-1:0] CH_ID = BLK_W'(ch + 1);
    logic mine;
    assign mine = bus_wen && aligned && (blk == CH_ID);

    tmr_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .sys_tick(sys_tick),
      .rtc_tick(rtc_tick),
      .ctl_we  (mine && slot == 2'd0),
      .sel_we  (mine && slot == 2'd1),
      .cmp_we  (mine && slot == 2'd3),
      .wdata   (bus_wdata),
      .ctl_q   (ctl_q[ch]),
      .sel_q   (sel_q[ch]),
      .cnt_q   (cnt_q[ch]),
      .cmp_q   (cmp_q[ch]),
      .hit     (hits[ch])
    );
  end

  tmr_irq_ctrl #(.N_CH(N_CH)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .en_we (bus_wen && shared_hit && slot == 2'd0),
    .ack_we(bus_wen && shared_hit && slot == 2'd2),
    .wbits (bus_wdata[N_CH-1:0]),
    .hits  (hits),
    .en_q  (en_q),
    .stat_q(stat_q),
    .irq   (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (shared_hit) begin
      if (slot == 2'd0) bus_rdata[N_CH-1:0] = en_q;
      if (slot == 2'd1) bus_rdata[N_CH-1:0] = stat_q;
    end
    for (int c = 0; c < N_CH; c++) begin
      if (aligned && blk == BLK_W'(c + 1)) begin
        case (slot)
          2'd0:    bus_rdata = ctl_q[c];
          2'd1:    bus_rdata = sel_q[c];
          2'd2:    bus_rdata = cnt_q[c];
          default: bus_rdata = cmp_q[c];
        endcase
      end
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!irq || rst_n));

  assert_irq_needs_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_q != '0));

endmodule

// File: tb/multi_timer_bench.sv
`timescale 1ns/100ps
module multi_timer_bench;
  localparam int N_CH = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sys_tick = 1'b1;
  logic        rtc_tick = 1'b0;
  logic        bus_wen = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int rtc_ph = 0;

  always #2.5 clk = ~clk;

  multi_timer u_multi_timer (
    .clk(clk), .rst_n(rst_n), .sys_tick(sys_tick), .rtc_tick(rtc_tick),
    .bus_wen(bus_wen), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  always @(negedge clk) begin
    rtc_ph = (rtc_ph == 4) ? 0 : rtc_ph + 1;
    rtc_tick <= (rtc_ph == 0);
  end

  // Behavioural reference model
  logic            m_run  [N_CH];
  logic [1:0]      m_mode [N_CH];
  logic            m_src  [N_CH];
  logic [3:0]      m_code [N_CH];
  logic [31:0]     m_cnt  [N_CH];
  logic [31:0]     m_cmp  [N_CH];
  int              m_pc   [N_CH];
  logic [N_CH-1:0] m_en;
  logic [N_CH-1:0] m_st;

  function automatic int div_for(input logic [3:0] c);
    if (c <= 4'd12) return int'(c) + 1;
    if (c == 4'd13) return 16;
    if (c == 4'd14) return 32;
    return 64;
  endfunction

  task automatic model_step();
    logic [N_CH-1:0] hit_v;
    logic [31:0]     nx;
    logic [N_CH-1:0] ack;
    hit_v = '0;
    if (!rst_n) begin
      for (int c = 0; c < N_CH; c++) begin
        m_run[c] = 0; m_mode[c] = 0; m_src[c] = 0; m_code[c] = 0;
        m_cnt[c] = 0; m_cmp[c] = 0; m_pc[c] = 0;
      end
      m_en = '0; m_st = '0;
      return;
    end
    for (int c = 0; c < N_CH; c++) begin
      if (bus_wen && bus_addr == 8'((c + 1) * 16)) begin
        m_run[c]  = bus_wdata[0];
        m_mode[c] = bus_wdata[5:4];
        if (bus_wdata[1]) begin m_cnt[c] = 0; m_pc[c] = 0; end
      end else if (m_run[c] && (m_src[c] ? rtc_tick : sys_tick)) begin
        if (m_pc[c] >= div_for(m_code[c]) - 1) begin
          m_pc[c] = 0;
          nx = m_cnt[c] + 32'd1;
          if (nx == m_cmp[c] && m_mode[c] != 2'd3) hit_v[c] = 1'b1;
          if (nx == m_cmp[c] && m_mode[c] == 2'd1) m_cnt[c] = 0;
          else m_cnt[c] = nx;
          if (nx == m_cmp[c] && m_mode[c] == 2'd0) m_run[c] = 0;
        end else begin
          m_pc[c] = m_pc[c] + 1;
        end
      end
      if (bus_wen && bus_addr == 8'((c + 1) * 16 + 4)) begin
        m_src[c] = bus_wdata[4]; m_code[c] = bus_wdata[3:0];
      end
      if (bus_wen && bus_addr == 8'((c + 1) * 16 + 12)) m_cmp[c] = bus_wdata;
    end
    ack = (bus_wen && bus_addr == 8'h08) ? bus_wdata[N_CH-1:0] : '0;
    m_st = (m_st & ~ack) | hit_v;
    if (bus_wen && bus_addr == 8'h00) m_en = bus_wdata[N_CH-1:0];
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    int b;
    b = int'(a[7:4]);
    if (a[1:0] != 2'b00) return 32'h0;
    if (a == 8'h00) return {27'h0, m_en};
    if (a == 8'h04) return {27'h0, m_st};
    if (b >= 1 && b <= N_CH) begin
      case (a[3:2])
        2'd0: return {26'h0, m_mode[b-1], 3'b000, m_run[b-1]};
        2'd1: return {27'h0, m_src[b-1], m_code[b-1]};
        2'd2: return m_cnt[b-1];
        default: return m_cmp[b-1];
      endcase
    end
    return 32'h0;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    model_step();
    #1;
    if (!done) begin
      check({31'h0, irq}, {31'h0, |(m_st & m_en)}, "R10 irq vs model");
      check(bus_rdata, model_read(bus_addr), "R2 read vs model");
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(a, v);
    check(v, exp, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v1, v2;
    idle(3);
    rst_n = 1'b1;
    // R1: reset state
    for (int n = 1; n <= N_CH; n++) begin
      for (int o = 0; o < 16; o += 4) rd_chk(8'(n * 16 + o), 32'h0, "R1 reset register");
    end
    rd_chk(8'h00, 32'h0, "R1 reset enable");
    rd_chk(8'h04, 32'h0, "R1 reset status");
    check({31'h0, irq}, 32'h0, "R1 reset irq");

    // R6: single-shot on channel 1, compare 5
    wr(8'h1C, 32'd5); wr(8'h08, 32'h1); wr(8'h10, 32'h03);
    idle(20);
    rd_chk(8'h18, 32'd5, "R6 count held at compare");
    rd_chk(8'h10, 32'h0, "R6 run dropped, R3 clear reads 0");
    rd_chk(8'h04, 32'h1, "R10 status latched while masked");
    check({31'h0, irq}, 32'h0, "R10 irq masked");
    wr(8'h00, 32'h1);
    #1 check({31'h0, irq}, 32'h1, "R10 irq after enable");
    wr(8'h08, 32'h1);
    rd_chk(8'h04, 32'h0, "R11 ack clears status");
    check({31'h0, irq}, 32'h0, "R11 irq low after ack");
    rd_chk(8'h08, 32'h0, "R11 ack reads 0");

    // R7: periodic on channel 2, divide-by-2, compare 3
    wr(8'h24, 32'h1); wr(8'h2C, 32'd3); wr(8'h20, 32'h13);
    idle(30);
    rd_chk(8'h24, 32'h1, "R4 clock-select readback");
    rd_chk(8'h04, 32'h2, "R7 periodic status");
    wr(8'h20, 32'h10);
    rd(8'h28, v1);
    check({31'h0, v1 < 32'd3}, 32'h1, "R7 count stays below compare");
    idle(10);
    rd(8'h28, v2);
    check(v2, v1, "R12 stopped count holds");

    // R8 and R4: wrapping mode on channel 3 from the slow strobe
    wr(8'h34, 32'h10); wr(8'h3C, 32'd2); wr(8'h30, 32'h23);
    idle(60);
    rd(8'h38, v1);
    check({31'h0, v1 > 32'd2}, 32'h1, "R8 count runs past compare");
    check({31'h0, (v1 >= 32'd10) && (v1 <= 32'd13)}, 32'h1, "R4 slow strobe rate");
    rd_chk(8'h04, 32'h6, "R8 wrapping status");

    // R9 and R5: timebase on channel 4, code 13 (divide-by-16)
    wr(8'h44, 32'hD); wr(8'h4C, 32'd3); wr(8'h40, 32'h33);
    idle(100);
    rd_chk(8'h48, 32'd6, "R5 divide-by-16 count");
    rd_chk(8'h04, 32'h6, "R9 timebase never flags");
    wr(8'h40, 32'h33);
    rd_chk(8'h48, 32'd0, "R3 clear zeroes count");
    rd_chk(8'h40, 32'h31, "R3 clear bit reads 0");

    // R5: codes 14 and 15 on channel 5
    wr(8'h54, 32'hE); wr(8'h5C, 32'd1); wr(8'h50, 32'h03);
    idle(40);
    rd_chk(8'h58, 32'd1, "R5 divide-by-32");
    wr(8'h54, 32'hF); wr(8'h5C, 32'd2); wr(8'h50, 32'h03);
    idle(100);
    rd_chk(8'h58, 32'd1, "R5 divide-by-64 first step");
    idle(40);
    rd_chk(8'h58, 32'd2, "R5 divide-by-64 second step");
    rd_chk(8'h50, 32'h0, "R6 channel 5 stopped");
    rd_chk(8'h04, 32'h16, "R9 status excludes timebase channel");

    // R13: unmapped and read-only locations
    wr(8'h0C, 32'hFFFF_FFFF);
    rd_chk(8'h0C, 32'h0, "R13 hole reads 0");
    wr(8'h64, 32'hFFFF_FFFF);
    rd_chk(8'h64, 32'h0, "R13 out-of-range reads 0");
    wr(8'h52, 32'hFFFF_FFFF);
    rd_chk(8'h50, 32'h0, "R13 unaligned write ignored");
    wr(8'h58, 32'h1234);
    rd_chk(8'h58, 32'd2, "R13 count read-only");
    rd_chk(8'h00, 32'h1, "R13 enable unchanged");

    wr(8'h08, 32'h3F);
    rd_chk(8'h04, 32'h0, "R11 acknowledge all");
    idle(4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule